// File: doc/BRIEF.md
# Unaligned DMA Address Sequencer

This block produces the address sequence for one DMA channel that moves a byte buffer across a system bus that only performs full-word accesses. The first and last byte of the buffer may sit at any byte offset. Each access goes out on the bus as a word-aligned address. With it go a byte count and little-endian byte-lane strobes, so that a partial first or last word moves only the bytes that belong to the buffer.

Software sets the current address with a direct write while the channel is idle, then starts the channel with a start strobe that also latches the inclusive end address. Instead, a descriptor-load strobe can set both addresses and start the channel in one cycle. The address phase leaves on a valid/ready interface. Valid stays high for as long as the channel runs. Address, count and strobes hold steady while ready is low. The current address advances only when an address phase is accepted. The channel stops after the access that reaches the end byte. It can also stop early, after the access in flight, when an end-of-transfer pulse arrives while the early-close enable is high.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset `cur_addr` is 0x00000000, and `ch_en`, `bus_valid` and `done` are 0.
- R2: While `bus_valid` is high, `bus_addr` equals `cur_addr` with bits [1:0] forced to zero.
- R3: A `sw_addr_wr` pulse loads `sw_addr_data` into `cur_addr` only while `ch_en` is 0. While `ch_en` is 1 the write is ignored.
- R4: A `desc_load` pulse while `ch_en` is 0 loads `desc_addr` as the current address and `desc_end` as the end byte, and sets `ch_en`. In that cycle it takes priority over `sw_addr_wr` and `sw_start`. While `ch_en` is 1 it is ignored.
- R5: A `sw_start` pulse while `ch_en` is 0 latches `sw_end_data` as the inclusive end byte and sets `ch_en`. `bus_valid` is high from the next cycle.
- R6: When the current address and the end byte are in different words, `bus_strb` bit i (i = 0..3, lane i = byte at word address + i) is set for every i from `cur_addr[1:0]` to 3. `bus_nbytes` is the number of set bits.
- R7: Accesses between the first and the last carry 4 bytes with `bus_strb` = 4'b1111.
- R8: When the current address and the end byte are in the same word, the lanes from `cur_addr[1:0]` to the end byte's bits [1:0] are set. This is the last access, or the only one.
- R9: `cur_addr` increases by `bus_nbytes` on each cycle where `bus_valid` and `bus_ready` are both high, and at no other time while `ch_en` is 1. While `bus_valid` is high and `bus_ready` is low, `bus_addr`, `bus_nbytes` and `bus_strb` hold.
- R10: After the last access is accepted, `ch_en` and `bus_valid` are 0 in the next cycle and `done` is 1 for exactly that one cycle.
- R11: An `eot` pulse while `close_en` is 1 lets the access on offer complete. The channel then stops as in R10. With `close_en` at 0 the pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_addr_wr | input | 1 | Direct write strobe for the current address |
| sw_addr_data | input | 32 | Data for the direct address write |
| sw_start | input | 1 | Start strobe, latches the end byte |
| sw_end_data | input | 32 | Inclusive end byte address used by `sw_start` |
| desc_load | input | 1 | Descriptor load strobe, sets both addresses and starts |
| desc_addr | input | 32 | Start address from the descriptor |
| desc_end | input | 32 | Inclusive end byte from the descriptor |
| close_en | input | 1 | Enables early close on `eot` |
| eot | input | 1 | End-of-transfer pulse |
| bus_valid | output | 1 | Address phase on offer |
| bus_ready | input | 1 | Bus accepts the address phase |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_nbytes | output | 3 | Byte count of this access (1..4) |
| bus_strb | output | 4 | Byte-lane strobes, bit i = lane i |
| cur_addr | output | 32 | Current address register |
| ch_en | output | 1 | Channel enabled |
| done | output | 1 | One-cycle pulse when the channel stops |

## Verification
A wrong count or stray update in the current address shows on `bus_addr` and `bus_strb` at the very next offered access. It also shows on `cur_addr` one cycle after the faulty handshake. An end-word comparison that is off stops the channel a word too early or too late. The cycle after the expected final handshake then shows a wrong `ch_en` or `done`. A channel state that ignores the idle guard or the close enable lets `cur_addr` move, or lets `ch_en` drop, in the cycle after the write or pulse that should have been ignored.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_CLOSE = 2'd2
  } ch_state_t;
endpackage

// File: rtl/dma_lane_calc.sv
module dma_lane_calc #(
  parameter int unsigned BYTES = 4,
  localparam int unsigned LW = $clog2(BYTES),
  localparam int unsigned NW = LW + 1
) (
  input  logic [LW-1:0] lo_lane,
  input  logic [LW-1:0] end_lane,
  input  logic          same_word,
  output logic [BYTES-1:0] strb,
  output logic [NW-1:0]    nbytes
);
  logic [LW-1:0] hi_lane;

  always_comb begin
    hi_lane = same_word ? end_lane : LW'(BYTES - 1);
    nbytes  = NW'(hi_lane) - NW'(lo_lane) + NW'(1);
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign strb[i] = (LW'(i) >= lo_lane) && (LW'(i) <= hi_lane);
  end
endmodule

// File: rtl/dma_addr_ctrl.sv
module dma_addr_ctrl
  import dma_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BYTES  = 4,
  localparam int unsigned LW = $clog2(BYTES),
  localparam int unsigned NW = LW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_addr_wr,
  input  logic [ADDR_W-1:0] sw_addr_data,
  input  logic              sw_start,
  input  logic [ADDR_W-1:0] sw_end_data,
  input  logic              desc_load,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [ADDR_W-1:0] desc_end,
  input  logic              close_en,
  input  logic              eot,
  input  logic              accept,
  input  logic [NW-1:0]     step,
  output logic [ADDR_W-1:0] cur_q,
  output logic [ADDR_W-1:0] end_q,
  output logic              same_word,
  output logic              running,
  output logic              done_q
);
  ch_state_t state_q;
  logic      close_now;

  assign same_word = (cur_q[ADDR_W-1:LW] == end_q[ADDR_W-1:LW]);
  assign running   = (state_q != CH_IDLE);
  assign close_now = eot && close_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      cur_q   <= '0;
      end_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == CH_IDLE) begin
        if (desc_load) begin
          cur_q   <= desc_addr;
          end_q   <= desc_end;
          state_q <= CH_RUN;
        end else begin
          if (sw_addr_wr) cur_q <= sw_addr_data;
          if (sw_start) begin
            end_q   <= sw_end_data;
            state_q <= CH_RUN;
          end
        end
      end else begin
        if (close_now) state_q <= CH_CLOSE;
        if (accept) begin
          cur_q <= cur_q + ADDR_W'(step);
          if (same_word || state_q == CH_CLOSE || close_now) begin
            state_q <= CH_IDLE;
            done_q  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BYTES  = 4,
  localparam int unsigned LW = $clog2(BYTES),
  localparam int unsigned NW = LW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_addr_wr,
  input  logic [ADDR_W-1:0] sw_addr_data,
  input  logic              sw_start,
  input  logic [ADDR_W-1:0] sw_end_data,
  input  logic              desc_load,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [ADDR_W-1:0] desc_end,
  input  logic              close_en,
  input  logic              eot,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [NW-1:0]     bus_nbytes,
  output logic [BYTES-1:0]  bus_strb,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              ch_en,
  output logic              done
);
  logic [ADDR_W-1:0] cur_q, end_q;
  logic              same_word, running, accept;

  assign accept = running && bus_ready;

  dma_addr_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sw_addr_wr(sw_addr_wr), .sw_addr_data(sw_addr_data),
    .sw_start(sw_start), .sw_end_data(sw_end_data),
    .desc_load(desc_load), .desc_addr(desc_addr), .desc_end(desc_end),
    .close_en(close_en), .eot(eot),
    .accept(accept), .step(bus_nbytes),
    .cur_q(cur_q), .end_q(end_q), .same_word(same_word),
    .running(running), .done_q(done)
  );

  dma_lane_calc #(.BYTES(BYTES)) u_lanes (
    .lo_lane(cur_q[LW-1:0]),
    .end_lane(end_q[LW-1:0]),
    .same_word(same_word),
    .strb(bus_strb),
    .nbytes(bus_nbytes)
  );

  assign bus_valid = running;
  assign bus_addr  = {cur_q[ADDR_W-1:LW], {LW{1'b0}}};
  assign cur_addr  = cur_q;
  assign ch_en     = running;
endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BYTES  = 4,
  localparam int unsigned LW = $clog2(BYTES),
  localparam int unsigned NW = LW + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_addr_wr,
  input logic              desc_load,
  input logic              close_en,
  input logic              eot,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NW-1:0]     bus_nbytes,
  input logic [BYTES-1:0]  bus_strb,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              ch_en,
  input logic              done
);
  p_addr_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_addr[LW-1:0] == '0 && bus_addr[ADDR_W-1:LW] == cur_addr[ADDR_W-1:LW]));

  p_count_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ($countones(bus_strb) == int'(bus_nbytes)));

  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready && !(eot && close_en)) |=>
      (bus_valid && $stable(bus_addr) && $stable(bus_strb) && $stable(bus_nbytes)));

  p_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready) |=> (cur_addr == $past(cur_addr) + ADDR_W'($past(bus_nbytes))));

  p_ignore_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && !(bus_valid && bus_ready)) |=> $stable(cur_addr));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ch_en && !bus_valid));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind dma_addr_seq dma_addr_seq_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_addr_wr(sw_addr_wr), .desc_load(desc_load),
  .close_en(close_en), .eot(eot), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_addr(bus_addr), .bus_nbytes(bus_nbytes), .bus_strb(bus_strb),
  .cur_addr(cur_addr), .ch_en(ch_en), .done(done)
);

// File: tb/dma_addr_seq_test.sv
module dma_addr_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_addr_wr = 0, sw_start = 0, desc_load = 0;
  logic [31:0] sw_addr_data = 0, sw_end_data = 0, desc_addr = 0, desc_end = 0;
  logic        close_en = 0, eot = 0, bus_ready = 0;
  logic        bus_valid, ch_en, done;
  logic [31:0] bus_addr, cur_addr;
  logic [2:0]  bus_nbytes;
  logic [3:0]  bus_strb;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_seq uut (
    .clk(clk), .rst_n(rst_n),
    .sw_addr_wr(sw_addr_wr), .sw_addr_data(sw_addr_data),
    .sw_start(sw_start), .sw_end_data(sw_end_data),
    .desc_load(desc_load), .desc_addr(desc_addr), .desc_end(desc_end),
    .close_en(close_en), .eot(eot),
    .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_nbytes(bus_nbytes), .bus_strb(bus_strb),
    .cur_addr(cur_addr), .ch_en(ch_en), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One accepted access: check what is offered, then handshake.
  task automatic beat(input string tag, input logic [31:0] a, input logic [3:0] s, input logic [2:0] n);
    @(negedge clk);
    chk({tag, " valid"}, 32'(bus_valid), 32'd1);
    chk({tag, " addr R2"}, bus_addr, a);
    chk({tag, " strb"}, 32'(bus_strb), 32'(s));
    chk({tag, " nbytes"}, 32'(bus_nbytes), 32'(n));
    bus_ready = 1;
    @(negedge clk);
    bus_ready = 0;
  endtask

  task automatic check_stopped(input string tag, input logic [31:0] final_addr);
    chk({tag, " done R10"}, 32'(done), 32'd1);
    chk({tag, " ch_en R10"}, 32'(ch_en), 32'd0);
    chk({tag, " valid R10"}, 32'(bus_valid), 32'd0);
    chk({tag, " cur R9"}, cur_addr, final_addr);
    @(negedge clk);
    chk({tag, " done pulse R10"}, 32'(done), 32'd0);
  endtask

  task automatic sw_run(input logic [31:0] st, input logic [31:0] en);
    @(negedge clk);
    sw_addr_wr = 1; sw_addr_data = st; sw_start = 1; sw_end_data = en;
    @(negedge clk);
    sw_addr_wr = 0; sw_start = 0;
  endtask

  task automatic t_reset;
    chk("R1 cur_addr", cur_addr, 32'h0);
    chk("R1 ch_en", 32'(ch_en), 32'd0);
    chk("R1 valid", 32'(bus_valid), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
  endtask

  task automatic t_idle_write;
    @(negedge clk);
    sw_addr_wr = 1; sw_addr_data = 32'h0000_5555;
    @(negedge clk);
    sw_addr_wr = 0;
    chk("R3 idle write", cur_addr, 32'h0000_5555);
    chk("R3 still idle", 32'(ch_en), 32'd0);
  endtask

  task automatic t_unaligned;
    sw_run(32'h0000_1001, 32'h0000_100A);
    chk("R5 ch_en after start", 32'(ch_en), 32'd1);
    beat("R6 first", 32'h1000, 4'b1110, 3'd3);
    beat("R7 middle", 32'h1004, 4'b1111, 3'd4);
    beat("R8 last", 32'h1008, 4'b0111, 3'd3);
    check_stopped("unaligned", 32'h0000_100B);
  endtask

  task automatic t_same_word;
    sw_run(32'h0000_2001, 32'h0000_2002);
    beat("R8 same word", 32'h2000, 4'b0110, 3'd2);
    check_stopped("same word", 32'h0000_2003);
  endtask

  task automatic t_aligned_stall;
    sw_run(32'h0000_3000, 32'h0000_3007);
    @(negedge clk);
    @(negedge clk);
    chk("R9 stall addr", bus_addr, 32'h3000);
    chk("R9 stall cur", cur_addr, 32'h3000);
    sw_addr_wr = 1; sw_addr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    sw_addr_wr = 0;
    chk("R3 busy write ignored", cur_addr, 32'h3000);
    desc_load = 1; desc_addr = 32'h0000_7777; desc_end = 32'h0000_7778;
    @(negedge clk);
    desc_load = 0;
    chk("R4 busy load ignored", cur_addr, 32'h3000);
    beat("R7 aligned 0", 32'h3000, 4'b1111, 3'd4);
    beat("R8 aligned 1", 32'h3004, 4'b1111, 3'd4);
    check_stopped("aligned", 32'h0000_3008);
  endtask

  task automatic t_desc_priority;
    @(negedge clk);
    desc_load = 1; desc_addr = 32'h0000_6003; desc_end = 32'h0000_6004;
    sw_addr_wr = 1; sw_addr_data = 32'h0000_9000; sw_start = 1; sw_end_data = 32'h0000_9fff;
    @(negedge clk);
    desc_load = 0; sw_addr_wr = 0; sw_start = 0;
    chk("R4 desc load cur", cur_addr, 32'h0000_6003);
    chk("R4 desc load ch_en", 32'(ch_en), 32'd1);
    beat("R6 desc first", 32'h6000, 4'b1000, 3'd1);
    beat("R8 desc last", 32'h6004, 4'b0001, 3'd1);
    check_stopped("desc", 32'h0000_6005);
  endtask

  task automatic t_eot_close;
    @(negedge clk);
    close_en = 1;
    desc_load = 1; desc_addr = 32'h0000_4000; desc_end = 32'h0000_40FF;
    @(negedge clk);
    desc_load = 0;
    beat("R7 eot pre0", 32'h4000, 4'b1111, 3'd4);
    beat("R7 eot pre1", 32'h4004, 4'b1111, 3'd4);
    eot = 1;
    @(negedge clk);
    eot = 0;
    chk("R11 access still offered", 32'(bus_valid), 32'd1);
    chk("R11 addr held", bus_addr, 32'h4008);
    beat("R11 final", 32'h4008, 4'b1111, 3'd4);
    check_stopped("eot close", 32'h0000_400C);
    close_en = 0;
  endtask

  task automatic t_eot_ignored;
    sw_run(32'h0000_5000, 32'h0000_5007);
    eot = 1;
    @(negedge clk);
    eot = 0;
    bus_ready = 1;
    @(negedge clk);
    bus_ready = 0;
    chk("R11 eot ignored ch_en", 32'(ch_en), 32'd1);
    chk("R11 eot ignored cur", cur_addr, 32'h5004);
    beat("R11 continue", 32'h5004, 4'b1111, 3'd4);
    check_stopped("eot ignored", 32'h0000_5008);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle_write();
    t_unaligned();
    t_same_word();
    t_aligned_stall();
    t_desc_priority();
    t_eot_close();
    t_eot_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule